// File: doc/BRIEF.md
# Time-Slotted Power-Up Sequencer

This block brings up a set of supply resources in a programmable order once a start request arrives. Time is divided into numbered slots of equal length. Each resource has a small configuration field holding the slot in which its enable should rise, or a code meaning the resource stays off. The slot counter advances on a slow timebase: a one-cycle enable pulse at about 32.768 kHz, derived from a low-frequency clock and sampled on the fast system clock.

Two slot lengths are available through a select input, which is captured when the sequence starts. Enables that share a slot rise on the same clock edge and stay high. The slow-clock output enable rises in slot 7. The system reset is released, and a one-cycle completion pulse is given, in slot 8. A power-down request clears every output at once and returns the block to idle.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rail_en`, `ck32_en`, `rst_release` and `seq_done` are all low and the block is idle.
- R2: `long_slot` is captured on the clock edge that accepts a start. A value of 0 gives 16 ticks per slot and 1 gives 66 ticks per slot. Changes to `long_slot` during a sequence have no effect.
- R3: When the block is idle and `start` is high at a clock edge (with `stop` low), slot 1 begins at that edge. Resources coded 1 enable at that same edge.
- R4: Resource i takes its field from `slot_cfg[3i+2:3i]`. A code s from 1 to 7 enables it at the edge where the slot counter reaches s. That edge is the one on which the (s-1)·L-th tick after the start edge is sampled, with L the slot length. Resources with equal codes rise together. While a sequence runs, any resource whose nonzero code is at or below the current slot is enabled.
- R5: A resource coded 0 is never enabled.
- R6: Once high, an enable stays high until `stop` or `rst`, even if its code changes.
- R7: `ck32_en` rises at the edge where slot 7 begins and stays high until cleared.
- R8: `rst_release` rises at the edge where slot 8 begins, which follows 7·L ticks after start. `seq_done` is high for exactly that one cycle. The sequence then holds.
- R9: `stop` high at an edge clears all outputs at that edge and returns the block to idle. `stop` takes priority over `start`.
- R10: `start` during a sequence or after completion has no effect, and code changes after completion have no effect. A new sequence requires `stop` first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse (~32.768 kHz) |
| start | input | 1 | Power-up request |
| stop | input | 1 | Power-down request, clears everything |
| long_slot | input | 1 | Slot length select: 0 = 16 ticks, 1 = 66 ticks |
| slot_cfg | input | 3·N_RES | Per-resource slot code, 0 = off, 1..7 = slot |
| rail_en | output | N_RES | Per-resource enable |
| ck32_en | output | 1 | Slow-clock output enable (slot 7) |
| rst_release | output | 1 | System reset release (slot 8) |
| seq_done | output | 1 | One-cycle pulse on completion |

## Verification
The hardest situations to reach are a `stop` that lands in the middle of a long-slot run and a code change that moves a resource to a slot the counter has already passed. Both need the sequence to be deep into its timeline when the disturbance arrives. The stimulus handles this by keeping `tick` dense and by choosing a random stop point and random mid-run code rewrites inside each run. The runs are also checked cycle by cycle against a tick-counting model. Directed runs cover the example slot assignment, all-off codes, and start requests repeated after completion.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
    localparam int SLOT_W     = 3;
    localparam int SLOT_CNT_W = 4;
    localparam int CODE_OFF   = 0;
    localparam int CK_SLOT    = 7;
    localparam int REL_SLOT   = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

    typedef logic [SLOT_CNT_W-1:0] slot_t;

    function automatic int slot_len(input logic long_sel, input int short_t, input int long_t);
        return long_sel ? long_t : short_t;
    endfunction
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
    import pwrseq_pkg::*;
#(
    parameter int SHORT_TICKS = 16,
    parameter int LONG_TICKS  = 66,
    localparam int TCNT_W     = $clog2(LONG_TICKS + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load,
    input  logic  run,
    input  logic  tick,
    input  logic  long_sel,
    output slot_t slot_nx
);
    slot_t             slot_q;
    logic [TCNT_W-1:0] tcnt_q, tcnt_nx;
    logic              long_q, long_nx;
    logic [TCNT_W-1:0] last_tick;

    always_comb begin
        last_tick = TCNT_W'(slot_len(long_q, SHORT_TICKS, LONG_TICKS) - 1);
        slot_nx   = slot_q;
        tcnt_nx   = tcnt_q;
        long_nx   = long_q;
        if (clear) begin
            slot_nx = '0;
            tcnt_nx = '0;
            long_nx = 1'b0;
        end else if (load) begin
            slot_nx = slot_t'(1);
            tcnt_nx = '0;
            long_nx = long_sel;
        end else if (run && tick) begin
            if (tcnt_q == last_tick) begin
                tcnt_nx = '0;
                slot_nx = slot_q + slot_t'(1);
            end else begin
                tcnt_nx = tcnt_q + TCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            tcnt_q <= '0;
            long_q <= 1'b0;
        end else begin
            slot_q <= slot_nx;
            tcnt_q <= tcnt_nx;
            long_q <= long_nx;
        end
    end
endmodule

// File: rtl/pwrseq_rail_bank.sv
module pwrseq_rail_bank
    import pwrseq_pkg::*;
#(
    parameter int N_RES = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    upd,
    input  slot_t                   slot_nx,
    input  logic [N_RES*SLOT_W-1:0] cfg,
    output logic [N_RES-1:0]        en
);
    for (genvar i = 0; i < N_RES; i++) begin : g_rail
        logic [SLOT_W-1:0] code;
        logic              hit;
        logic              en_q;

        assign code = cfg[i*SLOT_W +: SLOT_W];
        assign hit  = (code != SLOT_W'(CODE_OFF)) && (slot_t'(code) <= slot_nx);

        always_ff @(posedge clk) begin
            if (rst || clear)
                en_q <= 1'b0;
            else if (upd && hit)
                en_q <= 1'b1;
        end

        assign en[i] = en_q;
    end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int N_RES       = 12,
    parameter int SHORT_TICKS = 16,
    parameter int LONG_TICKS  = 66
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    start,
    input  logic                    stop,
    input  logic                    long_slot,
    input  logic [N_RES*SLOT_W-1:0] slot_cfg,
    output logic [N_RES-1:0]        rail_en,
    output logic                    ck32_en,
    output logic                    rst_release,
    output logic                    seq_done
);
    seq_state_e state_q, state_nx;
    slot_t      slot_nx;
    logic       go, run, upd;
    logic       ck_q, rel_q, done_q;

    assign go  = (state_q == SEQ_IDLE) && start && !stop;
    assign run = (state_q == SEQ_RUN) && !stop;
    assign upd = go || run;

    pwrseq_timer #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (stop),
        .load    (go),
        .run     (run),
        .tick    (tick),
        .long_sel(long_slot),
        .slot_nx (slot_nx)
    );

    pwrseq_rail_bank #(
        .N_RES(N_RES)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .clear  (stop),
        .upd    (upd),
        .slot_nx(slot_nx),
        .cfg    (slot_cfg),
        .en     (rail_en)
    );

    always_comb begin
        state_nx = state_q;
        if (stop)
            state_nx = SEQ_IDLE;
        else if (go)
            state_nx = SEQ_RUN;
        else if (run && slot_nx >= slot_t'(REL_SLOT))
            state_nx = SEQ_FIN;
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            state_q <= SEQ_IDLE;
            ck_q    <= 1'b0;
            rel_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            done_q  <= 1'b0;
            if (upd && slot_nx >= slot_t'(CK_SLOT))
                ck_q <= 1'b1;
            if (run && slot_nx >= slot_t'(REL_SLOT)) begin
                rel_q  <= 1'b1;
                done_q <= 1'b1;
            end
        end
    end

    assign ck32_en     = ck_q;
    assign rst_release = rel_q;
    assign seq_done    = done_q;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
    import pwrseq_pkg::*;
#(
    parameter int N_RES = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    stop,
    input logic [N_RES*SLOT_W-1:0] slot_cfg,
    input logic [N_RES-1:0]        rail_en,
    input logic                    ck32_en,
    input logic                    rst_release,
    input logic                    seq_done
);
    // R9: power-down clears all outputs at the next sample
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
        stop |=> (rail_en == '0 && !ck32_en && !rst_release && !seq_done));

    // R6: enables never fall without stop
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !stop |=> ((~rail_en & $past(rail_en)) == '0));

    // R8: completion pulse lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    // R8: release rises together with the completion pulse
    p_rel_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_release) |-> seq_done);

    // R7: the slow clock is up before or with reset release
    p_ck_before_rel_r7: assert property (@(posedge clk) disable iff (rst)
        rst_release |-> ck32_en);

    // R5: a rail only rises if its code was nonzero
    for (genvar i = 0; i < N_RES; i++) begin : g_off
        p_off_stays_low_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(rail_en[i]) |-> ($past(slot_cfg[i*SLOT_W +: SLOT_W]) != SLOT_W'(CODE_OFF)));
    end
endmodule

bind pwrseq_top pwrseq_chk #(.N_RES(N_RES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop       (stop),
    .slot_cfg   (slot_cfg),
    .rail_en    (rail_en),
    .ck32_en    (ck32_en),
    .rst_release(rst_release),
    .seq_done   (seq_done)
);

// File: tb/sim_pwrseq_top.sv
`timescale 1ns/1ps
module sim_pwrseq_top;
    localparam int N  = 12;
    localparam int SW = 3;
    localparam int TS = 16;
    localparam int TL = 66;

    logic          clk = 1'b0;
    logic          rst, tick, start, stop, long_slot;
    logic [N*SW-1:0] slot_cfg;
    logic [N-1:0]  rail_en;
    logic          ck32_en, rst_release, seq_done;

    int total = 0;
    int bad   = 0;

    // model state
    int          m_slot;   // 0 idle, 1..8
    int          m_tcnt;
    logic        m_long;
    logic [N-1:0] m_en;
    logic        m_ck, m_rel, m_done;

    always #2.5 clk = ~clk;

    pwrseq_top #(.N_RES(N), .SHORT_TICKS(TS), .LONG_TICKS(TL)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .stop(stop),
        .long_slot(long_slot), .slot_cfg(slot_cfg), .rail_en(rail_en),
        .ck32_en(ck32_en), .rst_release(rst_release), .seq_done(seq_done)
    );

    function automatic logic [N-1:0] hits(input logic [N*SW-1:0] cfg, input int s);
        logic [N-1:0] h;
        for (int i = 0; i < N; i++) begin
            int c;
            c = int'(cfg[i*SW +: SW]);
            h[i] = (c != 0) && (c <= s);
        end
        return h;
    endfunction

    task automatic model_edge();
        if (rst || stop) begin
            m_slot = 0; m_tcnt = 0; m_long = 1'b0;
            m_en = '0; m_ck = 1'b0; m_rel = 1'b0; m_done = 1'b0;
        end else if (m_slot == 0) begin
            m_done = 1'b0;
            if (start) begin
                m_slot = 1; m_tcnt = 0; m_long = long_slot;
                m_en = m_en | hits(slot_cfg, 1);
            end
        end else if (m_slot < 8) begin
            m_done = 1'b0;
            if (tick) begin
                if (m_tcnt == (m_long ? TL : TS) - 1) begin
                    m_tcnt = 0; m_slot++;
                end else m_tcnt++;
            end
            m_en = m_en | hits(slot_cfg, m_slot);
            if (m_slot >= 7) m_ck = 1'b1;
            if (m_slot == 8) begin m_rel = 1'b1; m_done = 1'b1; end
        end else begin
            m_done = 1'b0;
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle: inputs already set at negedge; model at posedge; compare at negedge
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R4 rail_en", 64'(rail_en), 64'(m_en));
        chk("R7 ck32_en", 64'(ck32_en), 64'(m_ck));
        chk("R8 rst_release", 64'(rst_release), 64'(m_rel));
        chk("R8 seq_done", 64'(seq_done), 64'(m_done));
    endtask

    task automatic do_stop();
        stop = 1'b1; start = 1'b0;
        cyc();
        chk("R9 cleared after stop", 64'({rail_en, ck32_en, rst_release, seq_done}), 64'(0));
        stop = 1'b0;
    endtask

    // run a sequence; tick every 'per' cycles; optional stop after stop_at cycles
    task automatic run_seq(input logic lsel, input int per, input int stop_at, input int rewrite_at);
        int n;
        n = 0;
        long_slot = lsel; start = 1'b1; tick = 1'b0;
        cyc();
        start = 1'b0;
        while (!(m_rel && !m_done) && n < 8000) begin
            tick = (n % per) == 0;
            long_slot = $urandom_range(0, 1);
            if (n == rewrite_at) slot_cfg = {$urandom, $urandom};
            if (n == stop_at) begin tick = 1'b0; do_stop(); return; end
            cyc();
            n++;
        end
        tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N*SW-1:0] ex;
        int t0;
        void'($urandom(32'd1234));
        rst = 1'b1; tick = 1'b0; start = 1'b0; stop = 1'b0; long_slot = 1'b0;
        // example assignment; resource 11 off
        ex = '0;
        ex[0*SW +: SW] = 3'd6; ex[1*SW +: SW] = 3'd7; ex[2*SW +: SW] = 3'd4;
        ex[3*SW +: SW] = 3'd2; ex[4*SW +: SW] = 3'd2; ex[5*SW +: SW] = 3'd1;
        ex[6*SW +: SW] = 3'd3; ex[7*SW +: SW] = 3'd3; ex[8*SW +: SW] = 3'd5;
        ex[9*SW +: SW] = 3'd5; ex[10*SW +: SW] = 3'd5; ex[11*SW +: SW] = 3'd0;
        slot_cfg = ex;
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk("R1 reset outputs", 64'({rail_en, ck32_en, rst_release, seq_done}), 64'(0));

        // R3: slot-1 resource rises at the start edge
        long_slot = 1'b0; start = 1'b1; cyc(); start = 1'b0;
        chk("R3 slot1 at start", 64'(rail_en), 64'(12'h020));
        // R2 short slot: after 16 ticks slot 2 resources come up
        t0 = 0;
        while (t0 < 16) begin tick = 1'b1; cyc(); t0++; end
        tick = 1'b0;
        chk("R2 short slot length", 64'(rail_en), 64'(12'h038));
        // R4 remaining slots, R10 start ignored while running
        start = 1'b1; tick = 1'b1;
        while (!m_rel) cyc();
        start = 1'b0; tick = 1'b0;
        chk("R8 release after slot 7", 64'(rst_release), 64'(1));
        chk("R5 off resource low", 64'(rail_en[11]), 64'(0));
        chk("R4 all used rails up", 64'(rail_en), 64'(12'h7FF));
        // R10: changes after completion ignored
        slot_cfg = '1; start = 1'b1; cyc(); cyc(); start = 1'b0;
        chk("R10 no effect after done", 64'(rail_en), 64'(12'h7FF));
        chk("R10 done not repeated", 64'(seq_done), 64'(0));
        // R9 stop with simultaneous start
        start = 1'b1; do_stop(); start = 1'b0;
        chk("R9 idle after stop", 64'(rail_en), 64'(0));

        // R2 long slot: after 65 ticks still slot 1, after 66 slot 2
        slot_cfg = ex; long_slot = 1'b1; start = 1'b1; cyc(); start = 1'b0;
        long_slot = 1'b0;
        t0 = 0;
        while (t0 < 65) begin tick = 1'b1; cyc(); t0++; end
        chk("R2 long slot not yet", 64'(rail_en), 64'(12'h020));
        cyc();
        tick = 1'b0;
        chk("R2 long slot reached", 64'(rail_en), 64'(12'h038));
        // R6: move passed resources to later slot, stay high
        slot_cfg[3*SW +: SW] = 3'd7; slot_cfg[5*SW +: SW] = 3'd0;
        repeat (3) cyc();
        chk("R6 sticky after recode", 64'(rail_en & 12'h028), 64'(12'h028));
        do_stop();

        // R5: all off
        slot_cfg = '0;
        run_seq(1'b0, 1, -1, -1);
        chk("R5 all off stays low", 64'(rail_en), 64'(0));
        do_stop();

        // random runs
        for (int r = 0; r < 24; r++) begin
            slot_cfg = {$urandom, $urandom};
            run_seq($urandom_range(0, 1), $urandom_range(1, 3),
                    ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 600)) : -1,
                    ($urandom_range(0, 1) == 0) ? int'($urandom_range(0, 400)) : -1);
            repeat (2) cyc();
            do_stop();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule